// File: doc/BRIEF.md
# Out-of-Order Issue Core with Tagged Result Broadcast

This block schedules simple arithmetic instructions that arrive in program order at the head of an instruction queue. It holds a small pool of reservation stations: three for add/subtract and two for multiply/divide. When an instruction issues, each source operand is resolved to either a value or the tag of the station that will produce it. The destination register is then renamed to the tag of the issuing station. A station starts its operation as soon as both operands are present. Execution is modelled by a per-station latency counter over plain 64-bit integer arithmetic.

Finished stations compete for one shared result bus, which carries a 64-bit value and a 4-bit producer tag. Every waiting station snoops this bus and captures any value whose tag it is waiting for. The register file accepts a broadcast only while that register is still renamed to the broadcasting tag. Because operands name producers and not registers, write-after-read and write-after-write name conflicts never hold back issue. Only a lack of free stations does. A register read port exposes each register's value and its pending-producer tag.

Top module: `dyn_sched_core`

## Requirements
- R1: After reset, no result is broadcast and every register r holds the value r with a pending tag of 0.
- R2: The head instruction issues (issue_fire high) only if a station of its class is free; otherwise it stalls and stays at the head.
- R3: Tag 0 means "no producer"; tags 1..3 name the add/subtract stations and 4..5 the multiply/divide stations; issue takes the lowest-numbered free station of the class.
- R4: After an instruction issues, the pending tag of its destination register equals the issuing station's tag until that station's result is written.
- R5: A station waiting on a tag captures the broadcast value carrying that tag and computes with it.
- R6: With operands ready and the bus free, an instruction issued in cycle n broadcasts in cycle n+L+2, where L is 2 for add/subtract, 10 for multiply and 40 for divide.
- R7: Op encodings are 0 add, 1 sub, 2 mul (low 64 bits of the product), 3 unsigned divide, with divide by zero giving all ones; at most one result is broadcast per cycle.
- R8: Among finished stations, the one that finished earliest broadcasts first; a tie goes to the lower tag; a loser keeps its result and broadcasts later.
- R9: A broadcast writes a register only if that register's pending tag still equals the broadcast tag; the later of two writers to the same register determines its final value.
- R10: Issue never stalls because of write-after-write or write-after-read name conflicts while a station of the class is free.
- R11: A station is freed by its broadcast and can be allocated again in the following cycle.
- R12: A source whose producer broadcasts in the cycle the consumer issues takes the broadcast value directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_valid | input | 1 | Queue head holds an instruction |
| iq_op | input | 2 | Operation code of the head instruction |
| iq_dst | input | 3 | Destination register |
| iq_src1 | input | 3 | First source register |
| iq_src2 | input | 3 | Second source register |
| issue_fire | output | 1 | Head instruction is accepted this cycle |
| bc_valid | output | 1 | Result bus carries a result |
| bc_tag | output | 4 | Tag of the broadcasting station |
| bc_data | output | 64 | Broadcast result value |
| rd_addr | input | 3 | Register read port address |
| rd_data | output | 64 | Value of the addressed register |
| rd_tag | output | 4 | Pending producer tag of the addressed register |

## Verification
The hardest situations to reach from the ports are two stations finishing in the same cycle, and a consumer that issues in exactly the cycle its producer broadcasts. For the first, the stimulus makes two adds wait on a single multiply result. Both wake together, finish together and contend for the bus, so the order of the tags on the bus shows how the tie is broken. For the second, the bench counts cycles from a known issue and presents the consumer so that it fires in the broadcast cycle. A later write to the same register, following a slow producer, shows that the stale broadcast is discarded.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_DIV = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EXEC, ST_DONE} st_e;
endpackage

// File: rtl/sched_station.sv
module sched_station
  import sched_pkg::*;
#(
  parameter int unsigned DW      = 64,
  parameter int unsigned TW      = 4,
  parameter int unsigned AGEW    = 8,
  parameter int unsigned LAT_ADD = 2,
  parameter int unsigned LAT_MUL = 10,
  parameter int unsigned LAT_DIV = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  op_e             alloc_op,
  input  logic [DW-1:0]   alloc_vj,
  input  logic [TW-1:0]   alloc_qj,
  input  logic [DW-1:0]   alloc_vk,
  input  logic [TW-1:0]   alloc_qk,
  input  logic            bc_valid,
  input  logic [TW-1:0]   bc_tag,
  input  logic [DW-1:0]   bc_data,
  input  logic            grant,
  output logic            busy,
  output logic            req,
  output logic [AGEW-1:0] age,
  output logic [DW-1:0]   result
);
  localparam int unsigned CW = $clog2(LAT_DIV + 1);

  st_e             st_q, st_d;
  op_e             op_q, op_d;
  logic [DW-1:0]   vj_q, vj_d, vk_q, vk_d, res_q, res_d;
  logic [TW-1:0]   qj_q, qj_d, qk_q, qk_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [AGEW-1:0] age_q, age_d;

  function automatic logic [CW-1:0] lat_of(input op_e op);
    case (op)
      OP_MUL:  return CW'(LAT_MUL - 1);
      OP_DIV:  return CW'(LAT_DIV - 1);
      default: return CW'(LAT_ADD - 1);
    endcase
  endfunction

  function automatic logic [DW-1:0] compute(input op_e op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      default: return (b == '0) ? '1 : a / b;
    endcase
  endfunction

  always_comb begin
    st_d = st_q; op_d = op_q; vj_d = vj_q; vk_d = vk_q; qj_d = qj_q; qk_d = qk_q;
    cnt_d = cnt_q; res_d = res_q; age_d = age_q;
    case (st_q)
      ST_IDLE: if (alloc) begin
        st_d = ST_WAIT; op_d = alloc_op;
        vj_d = alloc_vj; qj_d = alloc_qj; vk_d = alloc_vk; qk_d = alloc_qk;
      end
      ST_WAIT: begin
        if (bc_valid && qj_q != '0 && qj_q == bc_tag) begin vj_d = bc_data; qj_d = '0; end
        if (bc_valid && qk_q != '0 && qk_q == bc_tag) begin vk_d = bc_data; qk_d = '0; end
        if (qj_q == '0 && qk_q == '0) begin st_d = ST_EXEC; cnt_d = lat_of(op_q); end
      end
      ST_EXEC: begin
        if (cnt_q == '0) begin
          st_d = ST_DONE; res_d = compute(op_q, vj_q, vk_q); age_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (grant) st_d = ST_IDLE;
        else if (age_q != '1) age_d = age_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      age_q <= '0;
      qj_q  <= '0;
      qk_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      age_q <= age_d;
      qj_q  <= qj_d;
      qk_q  <= qk_d;
    end
  end

  always_ff @(posedge clk) begin
    op_q  <= op_d;
    vj_q  <= vj_d;
    vk_q  <= vk_d;
    res_q <= res_d;
  end

  assign busy   = (st_q != ST_IDLE);
  assign req    = (st_q == ST_DONE);
  assign age    = age_q;
  assign result = res_q;
endmodule

// File: rtl/sched_arb.sv
module sched_arb #(
  parameter int unsigned N    = 5,
  parameter int unsigned AGEW = 8
) (
  input  logic [N-1:0]           req,
  input  logic [N-1:0][AGEW-1:0] age,
  output logic [N-1:0]           grant
);
  logic [AGEW-1:0] best;
  logic            hit;

  always_comb begin
    grant = '0;
    best  = '0;
    hit   = 1'b0;
    for (int s = 0; s < int'(N); s++) begin
      if (req[s] && (!hit || age[s] > best)) begin
        grant    = '0;
        grant[s] = 1'b1;
        best     = age[s];
        hit      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sched_rename.sv
module sched_rename #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 64,
  parameter int unsigned TW   = 4,
  localparam int unsigned RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bc_valid,
  input  logic [TW-1:0]  bc_tag,
  input  logic [DW-1:0]  bc_data,
  input  logic           ren_en,
  input  logic [RAW-1:0] ren_dst,
  input  logic [TW-1:0]  ren_tag,
  input  logic [RAW-1:0] ra_a,
  input  logic [RAW-1:0] ra_b,
  input  logic [RAW-1:0] ra_c,
  output logic [DW-1:0]  va,
  output logic [TW-1:0]  ta,
  output logic [DW-1:0]  vb,
  output logic [TW-1:0]  tb,
  output logic [DW-1:0]  vc,
  output logic [TW-1:0]  tc
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic [TW-1:0] stat_q [NREG];
  logic [TW-1:0] stat_d [NREG];

  always_comb begin
    for (int r = 0; r < int'(NREG); r++) begin
      regs_d[r] = regs_q[r];
      stat_d[r] = stat_q[r];
      if (bc_valid && stat_q[r] == bc_tag) begin
        regs_d[r] = bc_data;
        stat_d[r] = '0;
      end
    end
    if (ren_en) stat_d[ren_dst] = ren_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(NREG); r++) begin
        regs_q[r] <= DW'(r);
        stat_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < int'(NREG); r++) begin
        regs_q[r] <= regs_d[r];
        stat_q[r] <= stat_d[r];
      end
    end
  end

  assign va = regs_q[ra_a];
  assign ta = stat_q[ra_a];
  assign vb = regs_q[ra_b];
  assign tb = stat_q[ra_b];
  assign vc = regs_q[ra_c];
  assign tc = stat_q[ra_c];
endmodule

// File: rtl/dyn_sched_core.sv
module dyn_sched_core
  import sched_pkg::*;
#(
  parameter int unsigned N_ADD   = 3,
  parameter int unsigned N_MUL   = 2,
  parameter int unsigned NREG    = 8,
  parameter int unsigned DW      = 64,
  parameter int unsigned TW      = 4,
  parameter int unsigned AGEW    = 8,
  parameter int unsigned LAT_ADD = 2,
  parameter int unsigned LAT_MUL = 10,
  parameter int unsigned LAT_DIV = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    iq_valid,
  input  logic [1:0]              iq_op,
  input  logic [$clog2(NREG)-1:0] iq_dst,
  input  logic [$clog2(NREG)-1:0] iq_src1,
  input  logic [$clog2(NREG)-1:0] iq_src2,
  output logic                    issue_fire,
  output logic                    bc_valid,
  output logic [TW-1:0]           bc_tag,
  output logic [DW-1:0]           bc_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [DW-1:0]           rd_data,
  output logic [TW-1:0]           rd_tag
);
  localparam int unsigned NST = N_ADD + N_MUL;

  logic [NST-1:0]           busy, req, grant, alloc_oh;
  logic [NST-1:0][AGEW-1:0] age;
  logic [NST-1:0][DW-1:0]   result;
  logic                     found, need_mul;
  logic [TW-1:0]            new_tag, ta, tb, qj, qk;
  logic [DW-1:0]            va, vb, vj, vk;
  op_e                      op;

  assign op       = op_e'(iq_op);
  assign need_mul = (op == OP_MUL) || (op == OP_DIV);

  always_comb begin
    alloc_oh = '0;
    found    = 1'b0;
    new_tag  = '0;
    for (int s = 0; s < int'(NST); s++) begin
      if (!found && !busy[s] && ((s >= int'(N_ADD)) == need_mul)) begin
        alloc_oh[s] = 1'b1;
        found       = 1'b1;
        new_tag     = TW'(s + 1);
      end
    end
  end

  assign issue_fire = iq_valid && found;

  always_comb begin
    vj = va; qj = ta; vk = vb; qk = tb;
    if (ta != '0 && bc_valid && ta == bc_tag) begin vj = bc_data; qj = '0; end
    if (tb != '0 && bc_valid && tb == bc_tag) begin vk = bc_data; qk = '0; end
  end

  sched_rename #(.NREG(NREG), .DW(DW), .TW(TW)) u_ren (
    .clk(clk), .rst_n(rst_n),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .ren_en(issue_fire), .ren_dst(iq_dst), .ren_tag(new_tag),
    .ra_a(iq_src1), .ra_b(iq_src2), .ra_c(rd_addr),
    .va(va), .ta(ta), .vb(vb), .tb(tb), .vc(rd_data), .tc(rd_tag)
  );

  for (genvar s = 0; s < int'(NST); s++) begin : g_st
    sched_station #(
      .DW(DW), .TW(TW), .AGEW(AGEW),
      .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
    ) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_oh[s] && issue_fire), .alloc_op(op),
      .alloc_vj(vj), .alloc_qj(qj), .alloc_vk(vk), .alloc_qk(qk),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .grant(grant[s]), .busy(busy[s]), .req(req[s]), .age(age[s]), .result(result[s])
    );
  end

  sched_arb #(.N(NST), .AGEW(AGEW)) u_arb (.req(req), .age(age), .grant(grant));

  always_comb begin
    bc_tag  = '0;
    bc_data = '0;
    for (int s = 0; s < int'(NST); s++) begin
      if (grant[s]) begin
        bc_tag  = bc_tag | TW'(s + 1);
        bc_data = bc_data | result[s];
      end
    end
  end
  assign bc_valid = |grant;
endmodule

// File: rtl/dyn_sched_chk.sv
module dyn_sched_chk #(
  parameter int unsigned N_ADD = 3,
  parameter int unsigned NST   = 5,
  parameter int unsigned TW    = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           iq_valid,
  input logic [1:0]     iq_op,
  input logic           issue_fire,
  input logic           bc_valid,
  input logic [TW-1:0]  bc_tag,
  input logic [NST-1:0] grant,
  input logic [NST-1:0] busy
);
  AST_FIRE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> iq_valid); // R2
  AST_ADD_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && !iq_op[1] && (&busy[N_ADD-1:0])) |-> !issue_fire); // R2
  AST_BUS_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> (bc_tag != '0 && int'(bc_tag) <= int'(NST))); // R3
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_GRANT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~busy) == '0)); // R8
  AST_FREED_AFTER_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((busy & $past(grant)) == '0)); // R11
endmodule

bind dyn_sched_core dyn_sched_chk #(.N_ADD(N_ADD), .NST(N_ADD + N_MUL), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_op(iq_op),
  .issue_fire(issue_fire), .bc_valid(bc_valid), .bc_tag(bc_tag),
  .grant(grant), .busy(busy)
);

// File: tb/dyn_sched_core_test.sv
`timescale 1ns/1ps
module dyn_sched_core_test;
  logic        clk, rst_n, iq_valid, issue_fire, bc_valid;
  logic [1:0]  iq_op;
  logic [2:0]  iq_dst, iq_src1, iq_src2, rd_addr;
  logic [3:0]  bc_tag, rd_tag;
  logic [63:0] bc_data, rd_data;
  logic [63:0] refr [8];
  int          n_run, n_fail;

  // program: {op, dst, src1, src2}; ops 0 add, 1 sub, 2 mul, 3 div
  localparam logic [10:0] PROG [8] = '{
    {2'd2, 3'd4, 3'd2, 3'd3}, {2'd0, 3'd5, 3'd4, 3'd1},
    {2'd1, 3'd4, 3'd7, 3'd1}, {2'd0, 3'd6, 3'd4, 3'd4},
    {2'd3, 3'd3, 3'd6, 3'd2}, {2'd0, 3'd2, 3'd1, 3'd1},
    {2'd2, 3'd1, 3'd5, 3'd2}, {2'd1, 3'd0, 3'd3, 3'd5}
  };

  dyn_sched_core uut (
    .clk(clk), .rst_n(rst_n), .iq_valid(iq_valid), .iq_op(iq_op),
    .iq_dst(iq_dst), .iq_src1(iq_src1), .iq_src2(iq_src2), .issue_fire(issue_fire),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] alu(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return (b == 64'd0) ? '1 : a / b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input logic [1:0] op, input logic [2:0] d, input logic [2:0] a,
                          input logic [2:0] b, output int stalls);
    stalls = 0;
    @(negedge clk);
    iq_valid = 1'b1; iq_op = op; iq_dst = d; iq_src1 = a; iq_src2 = b;
    #1;
    while (!issue_fire) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    iq_valid = 1'b0;
    refr[d] = alu(op, refr[a], refr[b]);
  endtask

  task automatic drain();
    repeat (100) @(negedge clk);
  endtask

  task automatic reg_sweep(input string req);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      @(negedge clk);
      check(rd_data == refr[r], req, rd_data, refr[r]);
      check(rd_tag == 4'd0, req, 64'(rd_tag), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int st, k;
    n_run = 0; n_fail = 0;
    iq_valid = 1'b0; iq_op = 2'd0; iq_dst = 3'd0; iq_src1 = 3'd0; iq_src2 = 3'd0; rd_addr = 3'd0;
    for (int r = 0; r < 8; r++) refr[r] = 64'(r);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(!bc_valid, "R1 no broadcast", 64'(bc_valid), 64'd0);
    reg_sweep("R1 reset registers");

    // R6/R3: add latency and tag, rename visible (R4)
    rd_addr = 3'd1;
    do_issue(2'd0, 3'd1, 3'd2, 3'd3, st);
    @(negedge clk);
    check(rd_tag == 4'd1, "R4 rename to tag", 64'(rd_tag), 64'd1);
    k = 1;
    while (!bc_valid && k < 100) begin @(negedge clk); k++; end
    check(k == 4, "R6 add latency", 64'(k), 64'd4);
    check(bc_tag == 4'd1, "R3 lowest add tag", 64'(bc_tag), 64'd1);
    check(bc_data == refr[1], "R7 add result", bc_data, refr[1]);
    drain();

    // R6/R3: multiply latency and tag
    do_issue(2'd2, 3'd4, 3'd2, 3'd3, st);
    k = 0;
    do begin @(negedge clk); k++; end while (!bc_valid && k < 100);
    check(k == 12, "R6 mul latency", 64'(k), 64'd12);
    check(bc_tag == 4'd4, "R3 first mul tag", 64'(bc_tag), 64'd4);
    check(bc_data == refr[4], "R7 mul result", bc_data, refr[4]);
    drain();

    // R12: consumer issues in the producer's broadcast cycle
    do_issue(2'd0, 3'd1, 3'd2, 3'd2, st);
    repeat (3) @(negedge clk);
    do_issue(2'd0, 3'd6, 3'd1, 3'd3, st);
    // R11: tag 1 was freed by its broadcast and is reused at once
    rd_addr = 3'd3;
    do_issue(2'd0, 3'd3, 3'd0, 3'd0, st);
    @(negedge clk);
    check(rd_tag == 4'd1, "R11 station reuse", 64'(rd_tag), 64'd1);
    drain();
    rd_addr = 3'd6;
    @(negedge clk);
    check(rd_data == refr[6], "R12 bypass value", rd_data, refr[6]);

    // R2: third multiply-class op stalls while both are busy
    do_issue(2'd3, 3'd6, 3'd7, 3'd2, st);
    do_issue(2'd3, 3'd7, 3'd6, 3'd0, st);
    do_issue(2'd2, 3'd0, 3'd1, 3'd2, st);
    check(st > 0, "R2 stall when full", 64'(st), 64'd1);
    drain();
    rd_addr = 3'd7;
    @(negedge clk);
    check(rd_data == refr[7], "R7 div by zero", rd_data, refr[7]);

    // R10/R9: WAW and WAR without stalls, later writer wins
    do_issue(2'd2, 3'd5, 3'd2, 3'd3, st);
    do_issue(2'd0, 3'd5, 3'd1, 3'd1, st);
    check(st == 0, "R10 no WAW stall", 64'(st), 64'd0);
    do_issue(2'd0, 3'd2, 3'd4, 3'd4, st);
    check(st == 0, "R10 no WAR stall", 64'(st), 64'd0);
    drain();
    rd_addr = 3'd5;
    @(negedge clk);
    check(rd_data == refr[5], "R9 later writer wins", rd_data, refr[5]);

    // R8/R5: two adds wake together on one multiply, lower tag first
    do_issue(2'd2, 3'd7, 3'd2, 3'd3, st);
    do_issue(2'd0, 3'd1, 3'd7, 3'd0, st);
    do_issue(2'd0, 3'd6, 3'd7, 3'd7, st);
    k = 0;
    do begin @(negedge clk); k++; end while (!(bc_valid && bc_tag == 4'd1) && k < 100);
    check(bc_valid && bc_tag == 4'd1, "R8 tie lower tag first", 64'(bc_tag), 64'd1);
    check(bc_data == refr[1], "R5 captured operand", bc_data, refr[1]);
    @(negedge clk);
    check(bc_valid && bc_tag == 4'd2, "R8 loser next cycle", 64'(bc_tag), 64'd2);
    check(bc_data == refr[6], "R5 loser result held", bc_data, refr[6]);
    drain();

    // table walk: dependent program, compared with in-order model
    for (int i = 0; i < 8; i++) begin
      do_issue(PROG[i][10:9], PROG[i][8:6], PROG[i][5:3], PROG[i][2:0], st);
    end
    drain();
    reg_sweep("R5 R9 program result");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule